// File: doc/BRIEF.md
# MSB-first signed sequential multiplier

This block multiplies two two's-complement operands one multiplier bit per clock, beginning with the sign bit. The sign bit carries a negative weight. Its partial product is therefore subtracted from a cleared accumulator in the first step. Each of the remaining steps doubles the accumulator and adds the multiplicand when the next multiplier bit is 1. Because of this, the operands never need their absolute values taken, and the result never needs a sign fix at the end.

A host presents both operands and pulses `start` while the unit is idle. The unit then raises `busy` for one operand width's worth of cycles. It pulses `done` for one cycle when the result is final. The result stays on `product` until the next accepted start. A parameter selects the product width:
- Narrow mode gives a result as wide as the operands. This is the low half of the true product, wrapping around on overflow.
- Wide mode gives a double-width result. Here the multiplicand is sign-extended, and the accumulator shifts as one double-width register.

Top module: `msb_signed_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy` = 0, `done` = 0 and `product` = 0.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is 1 in the following cycle.
- R3: `done` is high exactly WIDTH (32) cycles after the edge that accepted `start`. It stays high for one cycle only, and `busy` is 0 in that cycle.
- R4: A `start` sampled while `busy` is high has no effect. Changes on `mcand` or `mplier` after acceptance also have no effect. The result and the timing of `done` are those of the accepted operands.
- R5: With FULL_PRODUCT = 0, `product` equals the low WIDTH bits of the signed product of `mcand` and `mplier`. Results that overflow wrap modulo 2^WIDTH.
- R6: With FULL_PRODUCT = 1, `product` is 2*WIDTH bits wide and equals the exact signed product.
- R7: The most negative operand value times -1 gives the most negative value (0x80000000) in narrow mode, and +2^31 in wide mode.
- R8: After `done`, `product` holds its value in every cycle until another `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication; honoured only when idle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while the steps run |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | WIDTH or 2*WIDTH | Result, held until the next accepted start |

## Verification
The hardest situation to reach is a second `start` that lands on a cycle in which the unit is still busy. The same applies to operand inputs that change while steps remain, since that new data must be ignored. The bench launches a job and changes both operand inputs a few cycles later. It also pulses `start` again in mid-run, and it launches a further job in the very cycle that `done` is high. The reference model accepts only the first of these requests, and it expects `done` exactly WIDTH cycles after acceptance.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_SIGN = 2'd2,
        ACT_ADD  = 2'd3
    } dp_action_e;

    function automatic dp_action_e pick_action(input logic load, input logic run,
                                               input logic first);
        if (load)
            return ACT_LOAD;
        else if (run && first)
            return ACT_SIGN;
        else if (run)
            return ACT_ADD;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/smul_seq.sv
module smul_seq
    import smul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic first_step
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           done_q;

    assign busy       = (state_q == SEQ_RUN);
    assign done       = done_q;
    assign load       = start && !busy;
    assign first_step = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                if (start) begin
                    state_q <= SEQ_RUN;
                    cnt_q   <= '0;
                end
            end else if (cnt_q == LAST) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt_q == '0));

    a_r3_finish: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q == LAST) |=> (done && !busy));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_restart_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
    import smul_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter bit FULL_PRODUCT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  run,
    input  logic                  first_step,
    input  logic [WIDTH-1:0]      mcand,
    input  logic [WIDTH-1:0]      mplier,
    output logic [(FULL_PRODUCT ? 2*WIDTH : WIDTH)-1:0] product
);
    localparam int PW = FULL_PRODUCT ? 2 * WIDTH : WIDTH;

    logic [PW-1:0]    acc_q;
    logic [PW-1:0]    mcx_q;
    logic [WIDTH-1:0] mreg_q;
    logic [PW-1:0]    mc_ext;
    logic [PW-1:0]    addend;
    dp_action_e       act;

    generate
        if (FULL_PRODUCT) begin : g_wide
            assign mc_ext = {{(PW - WIDTH){mcand[WIDTH-1]}}, mcand};
        end else begin : g_narrow
            assign mc_ext = mcand;
        end
    endgenerate

    assign addend  = mreg_q[WIDTH-1] ? mcx_q : '0;
    assign act     = pick_action(load, run, first_step);
    assign product = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mcx_q  <= '0;
            mreg_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    acc_q  <= '0;
                    mcx_q  <= mc_ext;
                    mreg_q <= mplier;
                end
                ACT_SIGN: begin
                    acc_q  <= acc_q - addend;
                    mreg_q <= mreg_q << 1;
                end
                ACT_ADD: begin
                    acc_q  <= (acc_q << 1) + addend;
                    mreg_q <= mreg_q << 1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msb_signed_mul.sv
module msb_signed_mul
    import smul_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter bit FULL_PRODUCT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             busy,
    output logic             done,
    output logic [(FULL_PRODUCT ? 2*WIDTH : WIDTH)-1:0] product
);
    logic load;
    logic first_step;

    smul_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .load       (load),
        .first_step (first_step)
    );

    smul_datapath #(.WIDTH(WIDTH), .FULL_PRODUCT(FULL_PRODUCT)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .run        (busy),
        .first_step (first_step),
        .mcand      (mcand),
        .mplier     (mplier),
        .product    (product)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

// File: tb/test_msb_signed_mul.sv
module test_msb_signed_mul;
    localparam int  CLK_PERIOD = 10;
    localparam int  W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          busy_n, done_n, busy_w, done_w;
    logic [W-1:0]  prod_n;
    logic [2*W-1:0] prod_w;

    int vectors = 0;
    int fails = 0;
    string tag_n = "R5";
    string tag_w = "R6";

    always #(CLK_PERIOD / 2) clk = ~clk;

    msb_signed_mul #(.WIDTH(W), .FULL_PRODUCT(1'b0)) i_msb_signed_mul (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy_n), .done(done_n), .product(prod_n));

    msb_signed_mul #(.WIDTH(W), .FULL_PRODUCT(1'b1)) i_msb_signed_mul_wide (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy_w), .done(done_w), .product(prod_w));

    // behavioural reference, advanced on each rising edge
    logic           m_valid = 1'b0;
    logic           m_busy = 1'b0;
    logic           m_done = 1'b0;
    logic           m_rst = 1'b0;
    int             m_cnt = 0;
    longint         m_a = 0;
    longint         m_b = 0;
    logic [2*W-1:0] m_prod = '0;

    always @(posedge clk) begin
        m_valid = 1'b1;
        m_rst   = rst;
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_prod = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == W) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_prod = m_a * m_b;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt  = 0;
                m_a    = longint'($signed(mcand));
                m_b    = longint'($signed(mplier));
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid) begin
            string tb, td;
            tb = m_rst ? "R1" : "R2";
            td = m_rst ? "R1" : "R3";
            chk(tb, "busy narrow", 64'(busy_n), 64'(m_busy));
            chk(tb, "busy wide",   64'(busy_w), 64'(m_busy));
            chk(td, "done narrow", 64'(done_n), 64'(m_done));
            chk(td, "done wide",   64'(done_w), 64'(m_done));
            if (!m_busy) begin
                string pn, pw;
                pn = m_rst ? "R1" : (m_done ? tag_n : "R8");
                pw = m_rst ? "R1" : (m_done ? tag_w : "R8");
                chk(pn, "product narrow", 64'(prod_n), 64'(m_prod[W-1:0]));
                chk(pw, "product wide",   64'(prod_w), m_prod);
            end
        end
    end

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tn, input string tw, input int idle);
        @(negedge clk);
        tag_n = tn; tag_w = tw;
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + idle) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(32'd3, 32'd5, "R5", "R6", 2);
        run(-32'sd7, 32'd6, "R5", "R6", 2);
        run(32'd123456, -32'sd789, "R5", "R6", 3);
        run(32'h7fff_ffff, 32'h7fff_ffff, "R5", "R6", 2);   // narrow wraps
        run(32'h8000_0000, 32'hffff_ffff, "R7", "R7", 2);
        run(32'h8000_0000, 32'h8000_0000, "R5", "R6", 2);
        run(32'hffff_ffff, 32'hffff_ffff, "R5", "R6", 2);
        run(32'h0000_0000, 32'h8765_4321, "R5", "R6", 2);
        run(32'h1234_5678, 32'h0000_0001, "R5", "R6", 5);

        // R4: mid-run restart and operand changes must be ignored
        @(negedge clk);
        tag_n = "R4"; tag_w = "R4";
        mcand = 32'h0000_1111; mplier = 32'hffff_fff0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        mcand = 32'h5555_5555; mplier = 32'h3333_3333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // wait for done, then launch again in the done cycle
        while (!m_done) @(negedge clk);
        mcand = 32'hdead_beef; mplier = 32'h0000_0100; start = 1'b1;
        @(negedge clk);
        tag_n = "R2"; tag_w = "R2";
        start = 1'b0;
        repeat (W + 6) @(negedge clk);

        // R1: reset mid-run clears everything
        run(32'h0000_00ff, 32'h0000_00ff, "R5", "R6", 0);
        @(negedge clk);
        mcand = 32'd9; mplier = 32'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule